// File: doc/BRIEF.md
# Bilinear Interpolator Pipeline

This block resamples an 8-bit greyscale image at coordinates that are not whole pixels. Each clock it can take one word that holds the four source pixels surrounding the sample point, packed into 32 bits, along with the 14-bit horizontal and vertical fractional offsets of that point within the square. It returns the blended intensity a fixed number of clocks later, and a new result can leave on every clock.

The blend runs in two steps. The block first interpolates horizontally along the upper pair and along the lower pair. It then interpolates vertically between those two intermediate values. Every intermediate keeps the full product width, so no precision is lost before the single final rounding step. Address generation, memory access and the computation of the mapped coordinates are left to neighbouring logic.

Top module: `bilerp_pipe`

## Requirements
- R1: Pixel positions in `in_win` are fixed. Bits 7:0 hold top-left, bits 15:8 top-right, bits 23:16 bottom-left and bits 31:24 bottom-right. Offsets of 0 in both fractions select top-left. A horizontal offset of 16383 with a vertical offset of 0 yields top-right. The reverse pair yields bottom-left, and 16383 on both yields bottom-right.
- R2: When both fractions are zero, `out_pix` equals the top-left byte exactly.
- R3: `out_pix` equals floor((N + 2^27) / 2^28), clamped to 255. Here N = TL·(2^14−fx)(2^14−fy) + TR·fx(2^14−fy) + BL·(2^14−fx)fy + BR·fx·fy. This is round-to-nearest, with exact halves going up.
- R4: If all four neighbours hold the same value, the output equals that value for any pair of fractions.
- R5: `out_valid` repeats `in_valid` exactly 5 clocks later. Gaps in the input stream appear unchanged at the output.
- R6: An input sample is accepted on every clock that `in_valid` is high. Back-to-back samples each produce their own result on consecutive clocks.
- R7: While `rst_n` is low, `out_valid` and `out_pix` are 0.
- R8: On any clock where `out_valid` is low, `out_pix` keeps the value of the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this clock |
| in_win | input | 32 | Packed 2×2 neighbourhood, byte order as in R1 |
| in_fx | input | 14 | Horizontal fraction, units of 2^-14 |
| in_fy | input | 14 | Vertical fraction, units of 2^-14 |
| out_valid | output | 1 | Result present this clock |
| out_pix | output | 8 | Interpolated intensity |

## Verification
Two things can fall in the same clock: a valid result leaving the last stage, and a bubble from an earlier gap moving through the middle stages. The result must appear while the held value stays untouched elsewhere. The bench provokes this with a stream whose valid input is random at about one half, mixed with fully back-to-back runs. A delay-line reference model tracks both the expected result and the value held since the last valid output. On every clock it judges `out_valid`, and it judges `out_pix` against either the fresh result or the held one.

// File: rtl/bilerp_pipe.sv
module bilerp_pipe #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [4*PIX_W-1:0]   in_win,
  input  logic [FRAC_W-1:0]    in_fx,
  input  logic [FRAC_W-1:0]    in_fy,
  output logic                 out_valid,
  output logic [PIX_W-1:0]     out_pix
);
  localparam int DIF_W = PIX_W + 1;
  localparam int H_W   = PIX_W + FRAC_W + 2;
  localparam int V_W   = PIX_W + 2*FRAC_W + 2;
  localparam int SH    = 2*FRAC_W;
  localparam logic signed [V_W-1:0] RND  = V_W'(1) <<< (SH-1);
  localparam logic signed [V_W-1:0] PMAX = V_W'((1 << PIX_W) - 1);

  wire [PIX_W-1:0] tl = in_win[0*PIX_W +: PIX_W];
  wire [PIX_W-1:0] tr = in_win[1*PIX_W +: PIX_W];
  wire [PIX_W-1:0] bl = in_win[2*PIX_W +: PIX_W];
  wire [PIX_W-1:0] br = in_win[3*PIX_W +: PIX_W];

  // stage 1: horizontal differences
  logic                    s1_v;
  logic [PIX_W-1:0]        s1_top, s1_bot;
  logic signed [DIF_W-1:0] s1_dt, s1_db;
  logic [FRAC_W-1:0]       s1_fx, s1_fy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_top <= '0; s1_bot <= '0; s1_dt <= '0; s1_db <= '0;
      s1_fx <= '0; s1_fy <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_top <= tl;
        s1_bot <= bl;
        s1_dt  <= $signed({1'b0, tr}) - $signed({1'b0, tl});
        s1_db  <= $signed({1'b0, br}) - $signed({1'b0, bl});
        s1_fx  <= in_fx;
        s1_fy  <= in_fy;
      end
    end

  // stage 2: horizontal blends
  wire signed [H_W-1:0] fx_e  = $signed({{(H_W-FRAC_W){1'b0}}, s1_fx});
  wire signed [H_W-1:0] dt_e  = $signed({{(H_W-DIF_W){s1_dt[DIF_W-1]}}, s1_dt});
  wire signed [H_W-1:0] db_e  = $signed({{(H_W-DIF_W){s1_db[DIF_W-1]}}, s1_db});
  wire signed [H_W-1:0] top_e = $signed({{(H_W-PIX_W-FRAC_W){1'b0}}, s1_top, {FRAC_W{1'b0}}});
  wire signed [H_W-1:0] bot_e = $signed({{(H_W-PIX_W-FRAC_W){1'b0}}, s1_bot, {FRAC_W{1'b0}}});
  wire signed [H_W-1:0] h_top = top_e + fx_e * dt_e;
  wire signed [H_W-1:0] h_bot = bot_e + fx_e * db_e;

  logic                 s2_v;
  logic signed [H_W-1:0] s2_ht, s2_hb;
  logic [FRAC_W-1:0]    s2_fy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_v <= 1'b0; s2_ht <= '0; s2_hb <= '0; s2_fy <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_ht <= h_top;
        s2_hb <= h_bot;
        s2_fy <= s1_fy;
      end
    end

  // stage 3: vertical difference
  logic                 s3_v;
  logic signed [H_W-1:0] s3_ht, s3_dv;
  logic [FRAC_W-1:0]    s3_fy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s3_v <= 1'b0; s3_ht <= '0; s3_dv <= '0; s3_fy <= '0;
    end else begin
      s3_v <= s2_v;
      if (s2_v) begin
        s3_ht <= s2_ht;
        s3_dv <= s2_hb - s2_ht;
        s3_fy <= s2_fy;
      end
    end

  // stage 4: vertical blend at full precision
  wire signed [V_W-1:0] fy_e  = $signed({{(V_W-FRAC_W){1'b0}}, s3_fy});
  wire signed [V_W-1:0] dv_e  = $signed({{(V_W-H_W){s3_dv[H_W-1]}}, s3_dv});
  wire signed [V_W-1:0] ht_e  = $signed({{(V_W-H_W){s3_ht[H_W-1]}}, s3_ht});
  wire signed [V_W-1:0] blend = (ht_e <<< FRAC_W) + fy_e * dv_e;

  logic                 s4_v;
  logic signed [V_W-1:0] s4_acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s4_v <= 1'b0; s4_acc <= '0;
    end else begin
      s4_v <= s3_v;
      if (s3_v) s4_acc <= blend;
    end

  // stage 5: round half up, clamp
  wire signed [V_W-1:0] rnd = (s4_acc + RND) >>> SH;
  wire [PIX_W-1:0] sat = rnd[V_W-1] ? '0 :
                         (rnd > PMAX) ? {PIX_W{1'b1}} : rnd[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s4_v;
      if (s4_v) out_pix <= sat;
    end
endmodule

module bilerp_pipe_chk #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [4*PIX_W-1:0] in_win,
  input logic [FRAC_W-1:0]  in_fx,
  input logic [FRAC_W-1:0]  in_fy,
  input logic               out_valid,
  input logic [PIX_W-1:0]   out_pix
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd5) age <= age + 3'd1;

  wire warm = (age == 3'd5);
  wire zero_frac = in_valid && (in_fx == '0) && (in_fy == '0);
  wire flat = in_valid &&
              (in_win[0 +: PIX_W] == in_win[PIX_W +: PIX_W]) &&
              (in_win[0 +: PIX_W] == in_win[2*PIX_W +: PIX_W]) &&
              (in_win[0 +: PIX_W] == in_win[3*PIX_W +: PIX_W]);

  a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 5)));

  a_r2_zero_frac_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(zero_frac, 5)) |-> (out_pix == $past(in_win[0 +: PIX_W], 5)));

  a_r4_flat_window: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(flat, 5)) |-> (out_pix == $past(in_win[0 +: PIX_W], 5)));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 3'd0 && !out_valid) |-> $stable(out_pix));
endmodule

bind bilerp_pipe bilerp_pipe_chk #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/sim_bilerp_pipe.sv
module sim_bilerp_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int FRAC_W = 14;
  localparam int FMAX = (1 << FRAC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4*PIX_W-1:0] in_win = '0;
  logic [FRAC_W-1:0] in_fx = '0, in_fy = '0;
  logic out_valid;
  logic [PIX_W-1:0] out_pix;

  bilerp_pipe #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win),
    .in_fx(in_fx), .in_fy(in_fy), .out_valid(out_valid), .out_pix(out_pix));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string cur_tag = "R7";
  bit started = 1'b0;

  function automatic int ref_pix(logic [31:0] w, int fx, int fy);
    longint s, n, r;
    s = 64'd1 << FRAC_W;
    n = longint'(w[7:0])   * (s - fx) * (s - fy)
      + longint'(w[15:8])  * fx * (s - fy)
      + longint'(w[23:16]) * (s - fx) * fy
      + longint'(w[31:24]) * fx * fy;
    r = (n + (64'd1 << (2*FRAC_W - 1))) >> (2*FRAC_W);
    if (r > 255) r = 255;
    return int'(r);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // delay-line reference: 4 inner slots plus output register
  logic mv [4];
  int   mp [4];
  string mt [4];
  logic ov_m = 1'b0;
  int   op_m = 0;
  string ot_m = "R7";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin mv[i] <= 1'b0; mp[i] <= 0; mt[i] <= "R7"; end
      ov_m <= 1'b0; op_m <= 0;
    end else begin
      mv[0] <= in_valid;
      mp[0] <= ref_pix(in_win, int'(in_fx), int'(in_fy));
      mt[0] <= cur_tag;
      for (int i = 1; i < 4; i++) begin mv[i] <= mv[i-1]; mp[i] <= mp[i-1]; mt[i] <= mt[i-1]; end
      ov_m <= mv[3];
      if (mv[3]) begin op_m <= mp[3]; ot_m <= mt[3]; end
    end
  end

  always @(posedge clk) started <= 1'b1;

  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R5", "out_valid", int'(out_valid), int'(ov_m));
      if (ov_m) chk(ot_m, "out_pix", int'(out_pix), op_m);
      else      chk("R8", "held out_pix", int'(out_pix), op_m);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R6 watchdog: actual=%0d expected<=100000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic drive(logic v, logic [31:0] w, int fx, int fy, string tag);
    @(negedge clk);
    in_valid = v; in_win = w;
    in_fx = FRAC_W'(fx); in_fy = FRAC_W'(fy);
    cur_tag = tag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "reset out_valid", int'(out_valid), 0);
    chk("R7", "reset out_pix", int'(out_pix), 0);
    rst_n = 1'b1;

    // R1: corners select each byte
    drive(1, 32'h44332211, 0, 0, "R1");
    drive(1, 32'h44332211, FMAX, 0, "R1");
    drive(1, 32'h44332211, 0, FMAX, "R1");
    drive(1, 32'h44332211, FMAX, FMAX, "R1");
    drive(1, 32'h00FF00FF, FMAX, 0, "R1");
    drive(1, 32'hFF00FF00, 0, FMAX, "R1");
    drive(0, 0, 0, 0, "R1");
    repeat (6) drive(0, 0, 0, 0, "R1");
    // exact checks of the corner results against plain constants
    chk("R1", "ref top-left", ref_pix(32'h44332211, 0, 0), 8'h11);
    chk("R1", "ref bottom-right", ref_pix(32'h44332211, FMAX, FMAX), 8'h44);

    // R2: zero fractions return top-left
    for (int i = 0; i < 40; i++) drive(1, $urandom, 0, 0, "R2");

    // R3: rounding at exact halves and quarters
    drive(1, 32'h01000000, 8192, 8192, "R3");
    drive(1, 32'h01010000, 8192, 8192, "R3");
    drive(1, 32'h00000100, 8192, 0, "R3");
    drive(1, 32'hFFFFFF00, 8192, 8192, "R3");
    drive(1, 32'h000000FF, 1, 1, "R3");

    // R3/R6: random back-to-back stream
    for (int i = 0; i < 400; i++) drive(1, $urandom, $urandom_range(0, FMAX), $urandom_range(0, FMAX), "R6");

    // R4: flat windows
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      drive(1, {b, b, b, b}, $urandom_range(0, FMAX), $urandom_range(0, FMAX), "R4");
    end
    drive(1, 32'hFFFFFFFF, FMAX, FMAX, "R4");

    // R5/R8: bubbles
    for (int i = 0; i < 600; i++)
      drive(1'($urandom_range(0, 1)), $urandom, $urandom_range(0, FMAX), $urandom_range(0, FMAX), "R3");

    drive(0, 0, 0, 0, "R8");
    repeat (10) drive(0, $urandom, $urandom_range(0, FMAX), 0, "R8");

    @(negedge clk);
    summary();
    $finish;
  end
endmodule